// File: doc/BRIEF.md
# Filtered Memory Controller Event Counters

This block watches the command stream entering a memory controller's command queue and keeps two independent event counters and one free-running cycle timer, all readable through a small memory-mapped register port. Each counter is steered to one event type by a 4-bit code. For the filterable event types, a counter can be narrowed to commands from one master, to commands aimed at one address region, or to both at once.

Software programs the event codes and filters and clears or preloads the counters. It then reads the counters next to the timer to derive bandwidth and efficiency figures. Each cycle the controller presents a vector of event strobes, the master ID and region tag of the command, and a qualifier that is high when that command enters the queue. Strobes are ignored while the qualifier is low.

Top module: `pmc_unit`

## Requirements
- R1: After reset both counters, the timer, the configuration word and the filter-select word read zero, so both filters of both counters are off.
- R2: With filters off, counter k rises by one at the clock edge of each cycle in which `cmd_accept` is high and `evt_vec[code_k]` is high. Event codes 0 to 7 map to `evt_vec` bits 0 to 7 (0 any access, 1 read, 2 write, 3 activate, 4 precharge, 5 refresh, 6 row hit, 7 bus turnaround). The two counters count independently.
- R3: For codes 0 to 3, a counter whose master filter is on counts only when `cmd_mst` equals its programmed master ID.
- R4: For codes 0 to 3, a counter whose region filter is on counts only when `cmd_rgn` equals its programmed region.
- R5: When both filters of a counter are on, an event is counted only if both the master ID and the region match.
- R6: For codes 4 to 7 the filter enables have no effect, and every qualified strobe of the selected event is counted.
- R7: Codes 8 to 15 select no event, and the counter holds its value.
- R8: No event is counted in a cycle in which `cmd_accept` is low.
- R9: Counters wrap from all ones to zero.
- R10: A register write to a counter loads the written value. The write wins over an event in the same cycle.
- R11: The timer at 0x90 rises by one every clock cycle after reset is released. Writes to it are ignored.
- R12: Offsets: counter 1 at 0x80, counter 2 at 0x84, configuration at 0x88, filter select at 0x8C, timer at 0x90. Configuration bits: 31 counter 2 master filter on, 30 counter 2 region filter on, 19:16 counter 2 code, 15 counter 1 master filter on, 14 counter 1 region filter on, 3:0 counter 1 code. Select bits: 31:24 counter 2 master ID, 19:16 counter 2 region, 15:8 counter 1 master ID, 3:0 counter 1 region. Other bits read zero. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| cmd_accept | input | 1 | Command enters the command queue this cycle |
| evt_vec | input | 8 | Per-event strobes of the accepted command |
| cmd_mst | input | 8 | Master ID of the accepted command |
| cmd_rgn | input | 4 | Region tag of the accepted command |

## Verification
The assertions assume that the event inputs are meaningful only while `cmd_accept` is high. They also assume that a register write lasts one cycle with a stable address. The stimulus therefore raises the qualifier and the write strobe for exactly one cycle, changes them only at the falling clock edge, and returns them to zero before any read. Filter cases drive master and region tags that differ from the programmed ones in only one field at a time, so that each filter is tested on its own.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int CODE_W = 4;
    localparam int MID_W  = 8;
    localparam int RGN_W  = 4;
    localparam int N_EVT  = 8;
    localparam int N_FILT = 4;
    localparam int N_CTR  = 2;

    localparam logic [7:0] OFF_CNT0 = 8'h80;
    localparam logic [7:0] OFF_CFG  = 8'h88;
    localparam logic [7:0] OFF_SEL  = 8'h8C;
    localparam logic [7:0] OFF_TMR  = 8'h90;

    typedef struct packed {
        logic              mst_en;
        logic              rgn_en;
        logic [CODE_W-1:0] code;
    } ctr_cfg_t;

    typedef struct packed {
        logic [MID_W-1:0] mst;
        logic [RGN_W-1:0] rgn;
    } ctr_sel_t;
endpackage

// File: rtl/pmc_event_match.sv
module pmc_event_match
    import pmc_pkg::*;
#(
    parameter int NEVT  = N_EVT,
    parameter int NFILT = N_FILT
) (
    input  ctr_cfg_t         cfg,
    input  ctr_sel_t         sel,
    input  logic             accept,
    input  logic [NEVT-1:0]  evt,
    input  logic [MID_W-1:0] mst,
    input  logic [RGN_W-1:0] rgn,
    output logic             hit
);
    logic ev_sel;
    logic filterable;
    logic mst_ok;
    logic rgn_ok;

    always_comb begin
        ev_sel = 1'b0;
        for (int i = 0; i < NEVT; i++) begin
            if (cfg.code == CODE_W'(i)) ev_sel = evt[i];
        end
        filterable = (cfg.code < CODE_W'(NFILT));
        mst_ok = !(filterable && cfg.mst_en) || (mst == sel.mst);
        rgn_ok = !(filterable && cfg.rgn_en) || (rgn == sel.rgn);
        hit    = accept && ev_sel && mst_ok && rgn_ok;
    end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cstate_t;

    cstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)     st_d.cnt = load_val;
        else if (inc) st_d.cnt = st_q.cnt + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !inc) |=> $stable(cnt));
    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
    assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && (cnt == {W{1'b1}})) |=> (cnt == '0));
endmodule

// File: rtl/pmc_unit.sv
module pmc_unit
    import pmc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              cmd_accept,
    input  logic [N_EVT-1:0]  evt_vec,
    input  logic [MID_W-1:0]  cmd_mst,
    input  logic [RGN_W-1:0]  cmd_rgn
);
    localparam int DATA_W = 32;

    typedef struct packed {
        ctr_cfg_t [N_CTR-1:0] cfg;
        ctr_sel_t [N_CTR-1:0] sel;
        logic [CNT_W-1:0]     tmr;
    } ustate_t;

    ustate_t st_d, st_q;

    logic [N_CTR-1:0]            hit;
    logic [N_CTR-1:0]            ld;
    logic [N_CTR-1:0][CNT_W-1:0] cnt;
    logic                        wr_cfg, wr_sel;

    assign wr_cfg = reg_wr && (reg_addr == ADDR_W'(OFF_CFG));
    assign wr_sel = reg_wr && (reg_addr == ADDR_W'(OFF_SEL));

    always_comb begin
        st_d     = st_q;
        st_d.tmr = st_q.tmr + CNT_W'(1);
        if (wr_cfg) begin
            st_d.cfg[1].mst_en = reg_wdata[31];
            st_d.cfg[1].rgn_en = reg_wdata[30];
            st_d.cfg[1].code   = reg_wdata[19:16];
            st_d.cfg[0].mst_en = reg_wdata[15];
            st_d.cfg[0].rgn_en = reg_wdata[14];
            st_d.cfg[0].code   = reg_wdata[3:0];
        end
        if (wr_sel) begin
            st_d.sel[1].mst = reg_wdata[31:24];
            st_d.sel[1].rgn = reg_wdata[19:16];
            st_d.sel[0].mst = reg_wdata[15:8];
            st_d.sel[0].rgn = reg_wdata[3:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < N_CTR; k++) begin : g_ctr
        assign ld[k] = reg_wr && (reg_addr == ADDR_W'(OFF_CNT0 + 8'(4 * k)));

        pmc_event_match #(.NEVT(N_EVT), .NFILT(N_FILT)) u_match (
            .cfg    (st_q.cfg[k]),
            .sel    (st_q.sel[k]),
            .accept (cmd_accept),
            .evt    (evt_vec),
            .mst    (cmd_mst),
            .rgn    (cmd_rgn),
            .hit    (hit[k])
        );

        pmc_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld[k]),
            .load_val (reg_wdata[CNT_W-1:0]),
            .inc      (hit[k]),
            .cnt      (cnt[k])
        );

        assert_undef_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.cfg[k].code >= CODE_W'(N_EVT)) |-> !hit[k]);
        assert_nonfilt_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_accept && (st_q.cfg[k].code >= CODE_W'(N_FILT))
             && (st_q.cfg[k].code < CODE_W'(N_EVT)))
            |-> (hit[k] == evt_vec[st_q.cfg[k].code[2:0]]));
        assert_mst_filter_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[k] && st_q.cfg[k].mst_en && (st_q.cfg[k].code < CODE_W'(N_FILT)))
            |-> (cmd_mst == st_q.sel[k].mst));
        assert_rgn_filter_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[k] && st_q.cfg[k].rgn_en && (st_q.cfg[k].code < CODE_W'(N_FILT)))
            |-> (cmd_rgn == st_q.sel[k].rgn));
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFF_CFG)) begin
            reg_rdata = {st_q.cfg[1].mst_en, st_q.cfg[1].rgn_en, 10'b0, st_q.cfg[1].code,
                         st_q.cfg[0].mst_en, st_q.cfg[0].rgn_en, 10'b0, st_q.cfg[0].code};
        end else if (reg_addr == ADDR_W'(OFF_SEL)) begin
            reg_rdata = {st_q.sel[1].mst, 4'b0, st_q.sel[1].rgn,
                         st_q.sel[0].mst, 4'b0, st_q.sel[0].rgn};
        end else if (reg_addr == ADDR_W'(OFF_TMR)) begin
            reg_rdata = DATA_W'(st_q.tmr);
        end else begin
            for (int k = 0; k < N_CTR; k++) begin
                if (reg_addr == ADDR_W'(OFF_CNT0 + 8'(4 * k))) reg_rdata = DATA_W'(cnt[k]);
            end
        end
    end

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_accept |-> (hit == '0));
    assert_timer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.tmr == $past(st_q.tmr) + CNT_W'(1)));
endmodule

// File: tb/tb_pmc_unit.sv
module tb_pmc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_accept = 1'b0;
    logic [7:0]  evt_vec = '0;
    logic [7:0]  cmd_mst = '0;
    logic [3:0]  cmd_rgn = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pmc_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_accept(cmd_accept),
        .evt_vec(evt_vec), .cmd_mst(cmd_mst), .cmd_rgn(cmd_rgn)
    );

    typedef struct packed {
        logic [31:0] cfg;
        logic [31:0] sel;
        logic        acc;
        logic [7:0]  evt;
        logic [7:0]  mst;
        logic [3:0]  rgn;
        logic        e1;
        logic        e2;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{32'h0002_0001, 32'h0, 1'b1, 8'h02, 8'h00, 4'h0, 1'b1, 1'b0}, // R2 read only
        '{32'h0002_0001, 32'h0, 1'b1, 8'h06, 8'h00, 4'h0, 1'b1, 1'b1}, // R2 both counters
        '{32'h0002_0001, 32'h0, 1'b0, 8'h06, 8'h00, 4'h0, 1'b0, 1'b0}, // R8 not accepted
        '{32'h8000_8000, 32'h0900_0500, 1'b1, 8'h01, 8'h05, 4'h0, 1'b1, 1'b0}, // R3 master 5
        '{32'h8000_8000, 32'h0900_0500, 1'b1, 8'h01, 8'h09, 4'h0, 1'b0, 1'b1}, // R3 master 9
        '{32'h4000_4000, 32'h0007_0003, 1'b1, 8'h01, 8'h00, 4'h3, 1'b1, 1'b0}, // R4 region 3
        '{32'hC000_C000, 32'h0504_0503, 1'b1, 8'h01, 8'h05, 4'h3, 1'b1, 1'b0}, // R5 both match c1
        '{32'hC000_C000, 32'h0504_0503, 1'b1, 8'h01, 8'h06, 4'h3, 1'b0, 1'b0}, // R5 master miss
        '{32'hC007_8004, 32'h0504_0503, 1'b1, 8'h90, 8'h11, 4'hF, 1'b1, 1'b1}, // R6 non-filterable
        '{32'h000F_0008, 32'h0, 1'b1, 8'hFF, 8'h00, 4'h0, 1'b0, 1'b0}, // R7 undefined codes
        '{32'h4003_0003, 32'h0002_0000, 1'b1, 8'h08, 8'h00, 4'h5, 1'b1, 1'b0}  // R4 region miss c2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ev(input logic acc, input logic [7:0] e, input logic [7:0] m, input logic [3:0] r);
        @(negedge clk);
        cmd_accept = acc; evt_vec = e; cmd_mst = m; cmd_rgn = r;
        @(negedge clk);
        cmd_accept = 1'b0; evt_vec = '0; cmd_mst = '0; cmd_rgn = '0;
    endtask

    initial begin
        logic [31:0] v, t0, t1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h80, v); chk("R1 cnt1", v, 32'h0);
        rd(8'h84, v); chk("R1 cnt2", v, 32'h0);
        rd(8'h88, v); chk("R1 cfg", v, 32'h0);
        rd(8'h8C, v); chk("R1 sel", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(8'h88, VECS[i].cfg);
            wr(8'h8C, VECS[i].sel);
            wr(8'h80, 32'h0);
            wr(8'h84, 32'h0);
            ev(VECS[i].acc, VECS[i].evt, VECS[i].mst, VECS[i].rgn);
            rd(8'h80, v);
            checks++;
            if (v !== {31'b0, VECS[i].e1}) begin
                errors++;
                $display("FAIL vector %0d cnt1 (R2..R8 table) actual=%h expected=%h", i, v, VECS[i].e1);
            end
            rd(8'h84, v);
            checks++;
            if (v !== {31'b0, VECS[i].e2}) begin
                errors++;
                $display("FAIL vector %0d cnt2 (R2..R8 table) actual=%h expected=%h", i, v, VECS[i].e2);
            end
        end

        // R2 repeated counting, independence
        wr(8'h88, 32'h0003_0001);
        wr(8'h80, 32'h0); wr(8'h84, 32'h0);
        ev(1'b1, 8'h02, 8'h0, 4'h0);
        ev(1'b1, 8'h02, 8'h0, 4'h0);
        ev(1'b1, 8'h08, 8'h0, 4'h0);
        rd(8'h80, v); chk("R2 cnt1 two reads", v, 32'd2);
        rd(8'h84, v); chk("R2 cnt2 one activate", v, 32'd1);

        // R9 wrap
        wr(8'h88, 32'h0);
        wr(8'h80, 32'hFFFF_FFFF);
        ev(1'b1, 8'h01, 8'h0, 4'h0);
        rd(8'h80, v); chk("R9 wrap", v, 32'h0);

        // R10 write beats event in same cycle
        @(negedge clk);
        reg_addr = 8'h80; reg_wdata = 32'h0000_1234; reg_wr = 1'b1;
        cmd_accept = 1'b1; evt_vec = 8'h01;
        @(negedge clk);
        reg_wr = 1'b0; cmd_accept = 1'b0; evt_vec = '0;
        rd(8'h80, v); chk("R10 load wins", v, 32'h0000_1234);
        wr(8'h84, 32'hDEAD_BEEF);
        rd(8'h84, v); chk("R10 load cnt2", v, 32'hDEAD_BEEF);

        // R12 readback masks and unmapped offsets
        wr(8'h88, 32'hFFFF_FFFF);
        rd(8'h88, v); chk("R12 cfg mask", v, 32'hC00F_C00F);
        wr(8'h8C, 32'hFFFF_FFFF);
        rd(8'h8C, v); chk("R12 sel mask", v, 32'hFF0F_FF0F);
        rd(8'h94, v); chk("R12 unmapped 0x94", v, 32'h0);
        rd(8'h00, v); chk("R12 unmapped 0x00", v, 32'h0);

        // R11 timer
        rd(8'h90, t0);
        repeat (9) @(negedge clk);
        rd(8'h90, t1); chk("R11 timer step", t1 - t0, 32'd10);
        rd(8'h90, t0);
        wr(8'h90, 32'h0);
        rd(8'h90, t1); chk("R11 timer write ignored", t1 - t0, 32'd3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule